// File: doc/BRIEF.md
# Framed Serial Register Loader for a Phase-Accumulator Synthesizer

This block is the write port of a direct digital synthesizer. A host sends 16-bit words over three wires: a serial clock, a data line and an active-low frame strobe. The block samples all three with its own system clock. It assembles each framed word, most significant bit first, and takes one bit on every falling edge of the serial clock. It then decodes the word into a write to one of five registers: a 14-bit control register, two 28-bit tuning registers and two 12-bit phase registers. The register contents leave the block as plain outputs for the synthesizer datapath.

The top two bits of a word select its target. A tuning register can be loaded in two ways, chosen by the control register. In paired mode, two tuning writes form one atomic 28-bit update: the first carries the low 14 bits, and the register changes only when the second write arrives. In half mode, each write replaces the low or the high 14 bits, as a control bit selects. A frame that closes before 16 bits have arrived has no effect.

Two state machines do the work. The frame shifter has the states SH_IDLE, SH_SHIFT and SH_HOLD. Its transitions are: frame fall (SH_IDLE to SH_SHIFT, which clears the bit counter); sixteenth bit (SH_SHIFT to SH_HOLD, which emits the word); early frame rise (SH_SHIFT to SH_IDLE, which drops the partial word); and frame end (SH_HOLD to SH_IDLE). The pairing sequencer has the states PAIR_LOW and PAIR_HIGH. Its transitions are: low half taken (PAIR_LOW to PAIR_HIGH); pair complete (PAIR_HIGH to PAIR_LOW); and pairing cleared (to PAIR_LOW on any control write that turns paired mode off).

Top module: `serial_reg_loader`

## Requirements
- R1: After reset, every register output (ctrl_bits, tune0, tune1, phase0, phase1) reads zero.
- R2: A complete word whose bits 15:14 are 00 loads its bits 13:0 into ctrl_bits. In ctrl_bits, bit 13 selects paired mode, bit 12 selects the high half for half-mode writes, and bits 11 and 5 are passed through for the datapath.
- R3: With ctrl_bits[13]=0 and ctrl_bits[12]=0, a word with bits 15:14 equal to 01 (tune0) or 10 (tune1) replaces bits 13:0 of the addressed register and leaves its bits 27:14 unchanged.
- R4: With ctrl_bits[13]=0 and ctrl_bits[12]=1, such a tuning word replaces bits 27:14 of the addressed register and leaves bits 13:0 unchanged.
- R5: With ctrl_bits[13]=1, the first tuning word changes no register. The second tuning word loads {second[13:0], first[13:0]} into the register that the second word addresses.
- R6: A word with bits 15:14 equal to 11 writes its bits 11:0 into phase1 if bit 13 is 1, and into phase0 otherwise. Bit 12 is ignored, and the other phase register is unchanged.
- R7: If the frame strobe rises before the sixteenth falling edge of the serial clock, the partial word changes no register.
- R8: Each falling edge of the frame strobe restarts the bit count, so a full word sent after an aborted frame is decoded correctly.
- R9: Control writes that keep bit 13 set, and phase writes, between the two halves of a pair do not break the pair. A control write with bit 13 clear discards a pending low half.
- R10: Serial clock edges after the sixteenth bit within the same frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; a bit is taken on its falling edge |
| sdata | input | 1 | Serial data, most significant bit first |
| frame_n | input | 1 | Active-low word frame strobe |
| ctrl_bits | output | 14 | Control register contents |
| tune0 | output | 28 | Tuning register 0 |
| tune1 | output | 28 | Tuning register 1 |
| phase0 | output | 12 | Phase register 0 |
| phase1 | output | 12 | Phase register 1 |

## Verification
A wrong bit count or a wrong shifter state shows at the ports within one word. The decoded word then lands in the wrong register or carries a shifted payload, and either error is visible a few system clocks after the sixteenth serial edge. A pairing sequencer stuck in the wrong state shows as a tuning register that changes on the first half of a pair, or that stays put on the second half. The bench detects this by checking the registers after every half. Aborted frames, trailing edges and interleaved writes each get a word of their own, so a fault that swallows or shifts a word shows up in the very next register check.

// File: rtl/loader_pkg.sv
package loader_pkg;
    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_HOLD} shift_state_t;
    typedef enum logic {PAIR_LOW, PAIR_HIGH} pair_state_t;

    localparam logic [1:0] ADDR_CTRL  = 2'b00;
    localparam logic [1:0] ADDR_TUNE0 = 2'b01;
    localparam logic [1:0] ADDR_TUNE1 = 2'b10;
    localparam logic [1:0] ADDR_PHASE = 2'b11;
endpackage

// File: rtl/loader_sync.sv
module loader_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[s] <= RST_VAL;
            end else if (s == 0) begin
                pipe[s] <= d_in;
            end else begin
                pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/loader_shifter.sv
module loader_shifter
    import loader_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              frame_n_s,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int              CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    shift_state_t     state, state_nx;
    logic             sclk_q, frame_q;
    logic [CNT_W-1:0] cnt;
    logic             sclk_fall, frame_fall, frame_high;

    assign sclk_fall  = sclk_q & ~sclk_s;
    assign frame_fall = frame_q & ~frame_n_s;
    assign frame_high = frame_n_s;

    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE:  if (frame_fall) state_nx = SH_SHIFT;
            SH_SHIFT: begin
                if (frame_high) state_nx = SH_IDLE;
                else if (sclk_fall && cnt == LAST) state_nx = SH_HOLD;
            end
            SH_HOLD:  if (frame_high) state_nx = SH_IDLE;
            default:  state_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q     <= 1'b1;
            frame_q    <= 1'b1;
            cnt        <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            sclk_q     <= sclk_s;
            frame_q    <= frame_n_s;
            word_valid <= 1'b0;
            if (state == SH_IDLE && frame_fall) begin
                cnt <= '0;
            end else if (state == SH_SHIFT && !frame_high && sclk_fall) begin
                word <= {word[WORD_W-2:0], sdata_s};
                cnt  <= cnt + 1'b1;
                if (cnt == LAST) word_valid <= 1'b1;
            end
        end
    end

    assert_word_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> state == SH_HOLD);
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    assert_count_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_IDLE && frame_fall) |=> (cnt == '0 && state == SH_SHIFT));
endmodule

// File: rtl/loader_decoder.sv
module loader_decoder
    import loader_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int PHASE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-3:0] ctrl_bits,
    output logic [2*(WORD_W-2)-1:0] tune0,
    output logic [2*(WORD_W-2)-1:0] tune1,
    output logic [PHASE_W-1:0] phase0,
    output logic [PHASE_W-1:0] phase1
);
    localparam int HALF_W  = WORD_W - 2;
    localparam int TUNE_W  = 2 * HALF_W;
    localparam int PAIR_BIT = HALF_W - 1;
    localparam int HIGH_BIT = HALF_W - 2;
    localparam int PSEL_BIT = HALF_W - 1;

    pair_state_t       pair_st, pair_nx;
    logic [HALF_W-1:0] lo_hold;
    logic [1:0]        addr;
    logic [HALF_W-1:0] payload;
    logic              is_tune, paired, high_sel;

    assign addr     = word[WORD_W-1:WORD_W-2];
    assign payload  = word[HALF_W-1:0];
    assign is_tune  = (addr == ADDR_TUNE0) || (addr == ADDR_TUNE1);
    assign paired   = ctrl_bits[PAIR_BIT];
    assign high_sel = ctrl_bits[HIGH_BIT];

    function automatic logic [TUNE_W-1:0] merge(input logic [TUNE_W-1:0] old,
                                                input logic [HALF_W-1:0] pl,
                                                input logic [HALF_W-1:0] lo,
                                                input logic pr, input logic hs);
        if (pr)      return {pl, lo};
        else if (hs) return {pl, old[HALF_W-1:0]};
        else         return {old[TUNE_W-1:HALF_W], pl};
    endfunction

    always_comb begin
        pair_nx = pair_st;
        if (word_valid) begin
            unique case (pair_st)
                PAIR_LOW: begin
                    if (is_tune && paired) pair_nx = PAIR_HIGH;
                end
                PAIR_HIGH: begin
                    if (addr == ADDR_CTRL && !word[PAIR_BIT]) pair_nx = PAIR_LOW;
                    else if (is_tune) pair_nx = PAIR_LOW;
                end
                default: pair_nx = PAIR_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_st <= PAIR_LOW;
        else        pair_st <= pair_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_bits <= '0;
            tune0     <= '0;
            tune1     <= '0;
            phase0    <= '0;
            phase1    <= '0;
            lo_hold   <= '0;
        end else if (word_valid) begin
            unique case (addr)
                ADDR_CTRL: ctrl_bits <= payload;
                ADDR_TUNE0, ADDR_TUNE1: begin
                    if (paired && pair_st == PAIR_LOW) begin
                        lo_hold <= payload;
                    end else if (addr == ADDR_TUNE0) begin
                        tune0 <= merge(tune0, payload, lo_hold, paired, high_sel);
                    end else begin
                        tune1 <= merge(tune1, payload, lo_hold, paired, high_sel);
                    end
                end
                ADDR_PHASE: begin
                    if (word[PSEL_BIT]) phase1 <= word[PHASE_W-1:0];
                    else                phase0 <= word[PHASE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && addr == ADDR_CTRL) |=> ctrl_bits == $past(word[HALF_W-1:0]));
    assert_low_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && addr == ADDR_TUNE0 && !paired && !high_sel)
        |=> tune0[TUNE_W-1:HALF_W] == $past(tune0[TUNE_W-1:HALF_W]));
    assert_first_half_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && is_tune && paired && pair_st == PAIR_LOW)
        |=> ($stable(tune0) && $stable(tune1)));
    assert_phase_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && addr == ADDR_PHASE && !word[PSEL_BIT]) |=> $stable(phase1));
    assert_pair_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && addr == ADDR_CTRL && !word[PAIR_BIT]) |=> pair_st == PAIR_LOW);
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader #(
    parameter int WORD_W      = 16,
    parameter int PHASE_W     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk,
    input  logic                    sdata,
    input  logic                    frame_n,
    output logic [WORD_W-3:0]       ctrl_bits,
    output logic [2*(WORD_W-2)-1:0] tune0,
    output logic [2*(WORD_W-2)-1:0] tune1,
    output logic [PHASE_W-1:0]      phase0,
    output logic [PHASE_W-1:0]      phase1
);
    logic [2:0]        pins_s;
    logic              word_valid;
    logic [WORD_W-1:0] word;

    loader_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_in({sclk, sdata, frame_n}), .d_out(pins_s)
    );

    loader_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[2]), .sdata_s(pins_s[1]), .frame_n_s(pins_s[0]),
        .word_valid(word_valid), .word(word)
    );

    loader_decoder #(.WORD_W(WORD_W), .PHASE_W(PHASE_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word(word),
        .ctrl_bits(ctrl_bits), .tune0(tune0), .tune1(tune1),
        .phase0(phase0), .phase1(phase1)
    );
endmodule

// File: tb/tb_serial_reg_loader.sv
module tb_serial_reg_loader;
    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, sdata = 1'b0, frame_n = 1'b1;
    logic [13:0] ctrl_bits;
    logic [27:0] tune0, tune1;
    logic [11:0] phase0, phase1;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_reg_loader dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
        .frame_n(frame_n), .ctrl_bits(ctrl_bits), .tune0(tune0), .tune1(tune1),
        .phase0(phase0), .phase1(phase1));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input int extra);
        @(negedge clk); frame_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits + extra; i++) begin
            sdata = (i < nbits) ? w[15-i] : 1'b1;
            repeat (4) @(negedge clk); sclk = 1'b0;
            repeat (4) @(negedge clk); sclk = 1'b1;
        end
        repeat (4) @(negedge clk); frame_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic word16(input logic [15:0] w);
        send(w, 16, 0);
    endtask

    task automatic t_reset();
        check("R1 ctrl", 32'(ctrl_bits), 0);
        check("R1 tune0", 32'(tune0), 0);
        check("R1 tune1", 32'(tune1), 0);
        check("R1 phase", 32'({phase1, phase0}), 0);
    endtask

    task automatic t_ctrl();
        word16(16'h0821);
        check("R2 ctrl load", 32'(ctrl_bits), 32'h0821);
    endtask

    task automatic t_half();
        word16(16'h0000);
        word16(16'h4000 | 16'h1234);
        check("R3 tune0 low half", 32'(tune0), 32'h1234);
        word16(16'h1000);
        word16(16'h4000 | 16'h2ABC);
        check("R4 tune0 high half", 32'(tune0), 32'({14'h2ABC, 14'h1234}));
        word16(16'h8000 | 16'h0777);
        word16(16'h0000);
        word16(16'h8000 | 16'h0055);
        check("R3 tune1 low keeps high", 32'(tune1), 32'({14'h0777, 14'h0055}));
        check("R3 tune0 untouched", 32'(tune0), 32'({14'h2ABC, 14'h1234}));
    endtask

    task automatic t_pair();
        logic [27:0] t1_before;
        t1_before = tune1;
        word16(16'h2000);
        word16(16'h8000 | 16'h0155);
        check("R5 first half no change", 32'(tune1), 32'(t1_before));
        word16(16'h8000 | 16'h3FFF);
        check("R5 pair loads tune1", 32'(tune1), 32'({14'h3FFF, 14'h0155}));
    endtask

    task automatic t_interleave();
        word16(16'h4000 | 16'h0011);
        word16(16'hC000 | 16'h0123);
        word16(16'h2000);
        word16(16'h4000 | 16'h0022);
        check("R9 pair across writes", 32'(tune0), 32'({14'h0022, 14'h0011}));
        check("R9 phase0 written", 32'(phase0), 32'h123);
        word16(16'h4000 | 16'h0005);
        word16(16'h0000);
        word16(16'h2000);
        word16(16'h4000 | 16'h0007);
        check("R9 cleared pair restarts", 32'(tune0), 32'({14'h0022, 14'h0011}));
        word16(16'h4000 | 16'h0009);
        check("R9 new pair", 32'(tune0), 32'({14'h0009, 14'h0007}));
    endtask

    task automatic t_phase();
        word16(16'hF000 | 16'h0ABC);
        check("R6 phase1 written", 32'(phase1), 32'hABC);
        check("R6 phase0 kept", 32'(phase0), 32'h123);
        word16(16'hD000 | 16'h0456);
        check("R6 bit12 ignored", 32'(phase0), 32'h456);
    endtask

    task automatic t_abort();
        logic [27:0] t0_before;
        t0_before = tune0;
        send(16'h4000 | 16'h3333, 9, 0);
        check("R7 partial discarded tune0", 32'(tune0), 32'(t0_before));
        check("R7 partial discarded ctrl", 32'(ctrl_bits), 32'h2000);
        word16(16'h0800);
        check("R8 restart after abort", 32'(ctrl_bits), 32'h0800);
    endtask

    task automatic t_extra();
        send(16'h0020, 16, 5);
        check("R10 trailing edges ignored", 32'(ctrl_bits), 32'h0020);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_ctrl();
        t_half();
        t_pair();
        t_interleave();
        t_phase();
        t_abort();
        t_extra();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule